// File: doc/BRIEF.md
# Servo Axis Position Register with Station Preset

This block holds the running position count of one servo axis. Each qualified encoder step moves the count up or down by one. A control input can overwrite the count with a 15-bit station number. The overwrite is taken only on an off-to-on transition of that input, and only while the axis reports zero speed. An overwrite that is taken marks the axis as homed and clears a latched alarm for lost absolute data.

Alongside the position register, the block repeats the origin limit-switch level to the host. It also measures the homing margin: it counts encoder pulses from the moment the limit switch releases until the next index pulse. A small count warns that the switch sits too close to the index mark, so homing could land one revolution late.

Encoder decoding, motion control and parameter storage live elsewhere. The step, direction and index inputs arrive already decoded and synchronous to `clk`.

Top module: `servo_pos_preset`

## Requirements
- R1: The preset input passes through a two-flop synchronizer. A load occurs on the third rising clock edge after the input is first sampled high. Holding the input high never repeats the load; a new load needs the input to go low and then high again.
- R2: A load sets `position` to the station number zero-extended to the position width: bits 31 to 15 become 0 and bits 14 to 0 take `station_num`.
- R3: A synchronized edge loads only if `zero_speed` is 1 on the clock edge where the load would occur. Otherwise the edge is discarded. Raising `zero_speed` later, while the preset input stays high, does not produce a load.
- R4: While `preset_assigned` is 0 the preset input is treated as always off, and no load occurs.
- R5: A load sets `homed` to 1. `homed` then stays 1 until reset.
- R6: A one-cycle pulse on `abs_lost_set` sets `abs_lost_alarm`. A load clears it. When both happen on the same edge, the alarm ends up set.
- R7: When `step_valid` is 1, `position` changes by +1 if `step_up` is 1 and by −1 if it is 0. The count is 32-bit two's complement and wraps. When a load and a step fall on the same edge, the load wins and the step is lost.
- R8: `limsw_det` equals `limsw_in` at all times, with no register in the path.
- R9: On the first clock edge after `limsw_in` goes from 1 to 0, `margin_count` becomes 0 and counting starts. Every `step_valid` cycle adds 1, whatever the direction. A step in the same cycle as `index_pulse` is still counted. After the index pulse, `margin_done` is 1 and `margin_count` holds its value.
- R10: `margin_count` saturates at 2^MARGIN_W−1 instead of wrapping. The next 1-to-0 transition of `limsw_in` clears it to 0, clears `margin_done` and starts a new measurement.
- R11: A synchronous active-high `rst` sets `position`, `margin_count`, `homed`, `abs_lost_alarm` and `margin_done` to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| step_valid | input | 1 | One qualified encoder step this cycle |
| step_up | input | 1 | Step direction: 1 = up, 0 = down |
| index_pulse | input | 1 | Encoder index (Z) pulse |
| limsw_in | input | 1 | Origin limit-switch level |
| preset_in | input | 1 | Preset control input, asynchronous |
| preset_assigned | input | 1 | 1 when the preset input is mapped to a terminal |
| zero_speed | input | 1 | Axis is at zero speed |
| station_num | input | 15 | Station number to load |
| abs_lost_set | input | 1 | Pulse that latches the absolute-data-lost alarm |
| position | output | 32 | Current position, two's complement |
| homed | output | 1 | Homing-complete flag |
| abs_lost_alarm | output | 1 | Latched absolute-data-lost alarm |
| limsw_det | output | 1 | Origin limit-switch detection |
| margin_count | output | MARGIN_W | Steps from switch release to index |
| margin_done | output | 1 | Margin measurement finished and held |

## Verification
The assertions check several rules on every cycle:
- the synchronized edge never lasts two cycles;
- a load always yields the zero-extended station value;
- the position stays unchanged without a step when the speed gate or the terminal assignment blocks a load;
- `homed` is sticky;
- a load clears the alarm unless a set arrives on the same edge;
- the margin count holds after the index pulse and stays at its ceiling once saturated.

Only the bench scenarios can show the rest:
- the exact three-edge latency of a load;
- that an edge discarded for lack of zero speed is not deferred;
- that a held-high preset input never loads again;
- the priority of a load over a simultaneous step;
- wrap below zero;
- re-arming of the margin counter on a later switch release.

// File: rtl/servo_pos_pkg.sv
package servo_pos_pkg;

    typedef enum logic [1:0] {
        MG_IDLE  = 2'd0,
        MG_COUNT = 2'd1,
        MG_HELD  = 2'd2
    } margin_state_e;

    typedef struct packed {
        logic valid;
        logic up;
    } step_t;

endpackage

// File: rtl/preset_edge_sync.sv
module preset_edge_sync #(
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic preset_raw,
    output logic rise
);
    logic [SYNC_STAGES-1:0] chain;
    logic                   prev_q;

    always_ff @(posedge clk) begin
        if (rst) chain[0] <= 1'b0;
        else     chain[0] <= preset_raw;
    end

    genvar g;
    generate
        for (g = 1; g < SYNC_STAGES; g++) begin : g_stage
            always_ff @(posedge clk) begin
                if (rst) chain[g] <= 1'b0;
                else     chain[g] <= chain[g-1];
            end
        end
    endgenerate

    always_ff @(posedge clk) begin
        if (rst) prev_q <= 1'b0;
        else     prev_q <= chain[SYNC_STAGES-1];
    end

    assign rise = chain[SYNC_STAGES-1] & ~prev_q;

    // R1
    rise_single_chk: assert property (@(posedge clk) disable iff (rst)
        rise |=> !rise);

endmodule

// File: rtl/position_reg.sv
module position_reg
    import servo_pos_pkg::*;
#(
    parameter int POS_W     = 32,
    parameter int STATION_W = 15
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 load,
    input  logic [STATION_W-1:0] station,
    input  step_t                step,
    output logic [POS_W-1:0]     position
);
    localparam int PAD_W = POS_W - STATION_W;

    logic [POS_W-1:0] pos_q;

    always_ff @(posedge clk) begin
        if (rst)             pos_q <= '0;
        else if (load)       pos_q <= {{PAD_W{1'b0}}, station};
        else if (step.valid) pos_q <= step.up ? pos_q + 1'b1 : pos_q - 1'b1;
    end

    assign position = pos_q;

    // R2
    load_value_chk: assert property (@(posedge clk) disable iff (rst)
        load |=> position == {{PAD_W{1'b0}}, $past(station)});

    // R7
    step_move_chk: assert property (@(posedge clk) disable iff (rst)
        (!load && step.valid) |=>
            position == ($past(step.up) ? $past(position) + 1'b1
                                        : $past(position) - 1'b1));

endmodule

// File: rtl/margin_counter.sv
module margin_counter
    import servo_pos_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             limsw,
    input  logic             index_pulse,
    input  logic             step_valid,
    output logic [CNT_W-1:0] count,
    output logic             done
);
    localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

    margin_state_e    state_q;
    logic [CNT_W-1:0] cnt_q;
    logic             ls_q;
    logic             release_evt;

    assign release_evt = ls_q & ~limsw;

    always_ff @(posedge clk) begin
        if (rst) begin
            ls_q    <= 1'b0;
            cnt_q   <= '0;
            state_q <= MG_IDLE;
        end else begin
            ls_q <= limsw;
            if (release_evt) begin
                cnt_q   <= '0;
                state_q <= MG_COUNT;
            end else if (state_q == MG_COUNT) begin
                if (step_valid && cnt_q != CNT_MAX) cnt_q <= cnt_q + 1'b1;
                if (index_pulse) state_q <= MG_HELD;
            end
        end
    end

    assign count = cnt_q;
    assign done  = (state_q == MG_HELD);

    // R9
    held_stable_chk: assert property (@(posedge clk) disable iff (rst)
        (done && !release_evt) |=> ($stable(count) && done));

    // R10
    sat_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (count == CNT_MAX && !release_evt) |=> count == CNT_MAX);

endmodule

// File: rtl/servo_pos_preset.sv
module servo_pos_preset
    import servo_pos_pkg::*;
#(
    parameter int POS_W       = 32,
    parameter int STATION_W   = 15,
    parameter int MARGIN_W    = 16,
    parameter int SYNC_STAGES = 2
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 step_valid,
    input  logic                 step_up,
    input  logic                 index_pulse,
    input  logic                 limsw_in,
    input  logic                 preset_in,
    input  logic                 preset_assigned,
    input  logic                 zero_speed,
    input  logic [STATION_W-1:0] station_num,
    input  logic                 abs_lost_set,
    output logic [POS_W-1:0]     position,
    output logic                 homed,
    output logic                 abs_lost_alarm,
    output logic                 limsw_det,
    output logic [MARGIN_W-1:0]  margin_count,
    output logic                 margin_done
);
    logic  preset_rise;
    logic  load;
    step_t step;
    logic  homed_q;
    logic  alarm_q;

    assign step = '{valid: step_valid, up: step_up};

    preset_edge_sync #(.SYNC_STAGES(SYNC_STAGES)) u_sync (
        .clk        (clk),
        .rst        (rst),
        .preset_raw (preset_in),
        .rise       (preset_rise)
    );

    assign load = preset_rise & zero_speed & preset_assigned;

    position_reg #(.POS_W(POS_W), .STATION_W(STATION_W)) u_pos (
        .clk      (clk),
        .rst      (rst),
        .load     (load),
        .station  (station_num),
        .step     (step),
        .position (position)
    );

    margin_counter #(.CNT_W(MARGIN_W)) u_margin (
        .clk         (clk),
        .rst         (rst),
        .limsw       (limsw_in),
        .index_pulse (index_pulse),
        .step_valid  (step_valid),
        .count       (margin_count),
        .done        (margin_done)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            homed_q <= 1'b0;
            alarm_q <= 1'b0;
        end else begin
            if (load) homed_q <= 1'b1;
            if (abs_lost_set) alarm_q <= 1'b1;
            else if (load)    alarm_q <= 1'b0;
        end
    end

    assign homed          = homed_q;
    assign abs_lost_alarm = alarm_q;
    assign limsw_det      = limsw_in;

    // R5
    homed_sticky_chk: assert property (@(posedge clk) disable iff (rst)
        homed |=> homed);

    // R6
    alarm_clear_chk: assert property (@(posedge clk) disable iff (rst)
        (preset_rise && zero_speed && preset_assigned && !abs_lost_set) |=> !abs_lost_alarm);

    // R3
    no_load_slow_chk: assert property (@(posedge clk) disable iff (rst)
        (!zero_speed && !step_valid) |=> $stable(position));

    // R4
    no_load_unassigned_chk: assert property (@(posedge clk) disable iff (rst)
        (!preset_assigned && !step_valid) |=> $stable(position));

endmodule

// File: tb/test_servo_pos_preset.sv
`timescale 1ns/1ps
module test_servo_pos_preset;

    localparam int MW = 4;

    logic          clk = 1'b0;
    logic          rst;
    logic          step_valid, step_up, index_pulse, limsw_in;
    logic          preset_in, preset_assigned, zero_speed, abs_lost_set;
    logic [14:0]   station_num;
    logic [31:0]   position;
    logic          homed, abs_lost_alarm, limsw_det, margin_done;
    logic [MW-1:0] margin_count;

    always #2 clk = ~clk;

    servo_pos_preset #(.MARGIN_W(MW)) i_servo_pos_preset (
        .clk(clk), .rst(rst), .step_valid(step_valid), .step_up(step_up),
        .index_pulse(index_pulse), .limsw_in(limsw_in), .preset_in(preset_in),
        .preset_assigned(preset_assigned), .zero_speed(zero_speed),
        .station_num(station_num), .abs_lost_set(abs_lost_set),
        .position(position), .homed(homed), .abs_lost_alarm(abs_lost_alarm),
        .limsw_det(limsw_det), .margin_count(margin_count), .margin_done(margin_done)
    );

    typedef struct {
        int          cyc;
        int          kind;
        logic [31:0] val;
        string       tag;
    } exp_t;

    exp_t exp_q[$];
    int   cyc = 0;
    int   checks = 0;
    int   errors = 0;
    bit   finished = 0;

    always @(posedge clk) cyc <= cyc + 1;

    function automatic logic [31:0] observe(int kind);
        case (kind)
            0: return position;
            1: return {31'b0, homed};
            2: return {31'b0, abs_lost_alarm};
            3: return {31'b0, limsw_det};
            4: return {{(32-MW){1'b0}}, margin_count};
            default: return {31'b0, margin_done};
        endcase
    endfunction

    // monitor: pops due items and compares
    always @(negedge clk) begin
        for (int i = exp_q.size() - 1; i >= 0; i--) begin
            if (exp_q[i].cyc == cyc) begin
                checks++;
                if (observe(exp_q[i].kind) !== exp_q[i].val) begin
                    errors++;
                    $display("FAIL %s kind=%0d actual=%h expected=%h", exp_q[i].tag,
                             exp_q[i].kind, observe(exp_q[i].kind), exp_q[i].val);
                end
                exp_q.delete(i);
            end
        end
    end

    task automatic tick(int n);
        repeat (n) begin @(negedge clk); #1; end
    endtask

    // driver side: queue an expectation for the next sampling point
    task automatic expect_val(int kind, logic [31:0] val, string tag);
        exp_t e;
        e.cyc = cyc + 1; e.kind = kind; e.val = val; e.tag = tag;
        exp_q.push_back(e);
    endtask

    task automatic settle();
        tick(2);
    endtask

    task automatic steps(int n, bit up);
        for (int i = 0; i < n; i++) begin
            step_valid = 1'b1; step_up = up; tick(1);
        end
        step_valid = 1'b0;
    endtask

    task automatic preset_fire(logic [14:0] st, bit zs);
        station_num = st; zero_speed = zs; preset_in = 1'b0;
        tick(3);
        preset_in = 1'b1;
        tick(3);
    endtask

    initial begin
        rst = 1'b1; step_valid = 0; step_up = 0; index_pulse = 0; limsw_in = 0;
        preset_in = 0; preset_assigned = 1; zero_speed = 1; abs_lost_set = 0;
        station_num = '0;
        tick(4);
        rst = 1'b0;
        // R11 reset state
        expect_val(0, 32'd0, "R11 position");
        expect_val(1, 32'd0, "R11 homed");
        expect_val(2, 32'd0, "R11 alarm");
        expect_val(4, 32'd0, "R11 margin_count");
        expect_val(5, 32'd0, "R11 margin_done");
        settle();

        // R7 up and down counting, negative values
        steps(5, 1'b1); expect_val(0, 32'd5, "R7 up5"); settle();
        steps(3, 1'b0); expect_val(0, 32'd2, "R7 down3"); settle();
        steps(5, 1'b0); expect_val(0, 32'hFFFF_FFFD, "R7 negative"); settle();

        // R1 R2 R5 load and hold-high no repeat
        preset_fire(15'h7ABC, 1'b1);
        expect_val(0, 32'h0000_7ABC, "R2 load value");
        expect_val(1, 32'd1, "R5 homed set");
        settle();
        steps(2, 1'b1); tick(4);
        expect_val(0, 32'h0000_7ABE, "R1 held high no reload"); settle();
        preset_in = 1'b0;

        // R6 alarm set
        abs_lost_set = 1'b1; tick(1); abs_lost_set = 1'b0;
        expect_val(2, 32'd1, "R6 alarm set"); settle();

        // R3 edge without zero speed discarded, not deferred
        preset_fire(15'h0111, 1'b0);
        tick(1);
        zero_speed = 1'b1; tick(4);
        expect_val(0, 32'h0000_7ABE, "R3 gated edge ignored");
        expect_val(2, 32'd1, "R3 alarm untouched"); settle();
        preset_in = 1'b0;

        // R6 load clears alarm, R5 homed stays
        preset_fire(15'h0005, 1'b1);
        expect_val(0, 32'd5, "R2 second load");
        expect_val(2, 32'd0, "R6 alarm cleared");
        expect_val(1, 32'd1, "R5 homed sticky"); settle();

        // R6 set and load on the same edge: set wins
        preset_in = 1'b0; station_num = 15'h0123; tick(3);
        preset_in = 1'b1; tick(2);
        abs_lost_set = 1'b1; tick(1); abs_lost_set = 1'b0;
        expect_val(0, 32'h0000_0123, "R6 load with set");
        expect_val(2, 32'd1, "R6 set wins"); settle();

        // R7 load beats simultaneous step
        preset_in = 1'b0; station_num = 15'h0010; tick(3);
        preset_in = 1'b1; tick(2);
        step_valid = 1'b1; step_up = 1'b1; tick(1); step_valid = 1'b0;
        expect_val(0, 32'h0000_0010, "R7 load priority"); settle();

        // R4 unassigned terminal never loads
        preset_in = 1'b0; tick(3);
        preset_assigned = 1'b0;
        preset_fire(15'h7FFF, 1'b1);
        tick(2);
        expect_val(0, 32'h0000_0010, "R4 unassigned ignored"); settle();
        preset_in = 1'b0; tick(3);
        preset_assigned = 1'b1;

        // R7 wrap below zero
        preset_fire(15'h0000, 1'b1);
        expect_val(0, 32'd0, "R2 load zero"); settle();
        preset_in = 1'b0;
        steps(1, 1'b0);
        expect_val(0, 32'hFFFF_FFFF, "R7 wrap"); settle();

        // R8 pass-through
        limsw_in = 1'b1; expect_val(3, 32'd1, "R8 limsw on"); settle();

        // R9 margin measurement
        limsw_in = 1'b0; expect_val(3, 32'd0, "R8 limsw off"); tick(1);
        expect_val(4, 32'd0, "R9 cleared on release");
        expect_val(5, 32'd0, "R9 not done"); settle();
        steps(3, 1'b1); steps(2, 1'b0);
        index_pulse = 1'b1; step_valid = 1'b1; tick(1);
        index_pulse = 1'b0; step_valid = 1'b0;
        expect_val(4, 32'd6, "R9 count with index step");
        expect_val(5, 32'd1, "R9 done"); settle();
        steps(2, 1'b1);
        expect_val(4, 32'd6, "R9 hold after index"); settle();

        // R10 saturation and re-arm
        limsw_in = 1'b1; tick(1); limsw_in = 1'b0; tick(1);
        steps(20, 1'b1);
        expect_val(4, 32'd15, "R10 saturate");
        expect_val(5, 32'd0, "R10 still counting"); settle();
        index_pulse = 1'b1; tick(1); index_pulse = 1'b0;
        expect_val(5, 32'd1, "R10 done at ceiling");
        expect_val(4, 32'd15, "R10 ceiling held"); settle();
        limsw_in = 1'b1; tick(1); limsw_in = 1'b0; tick(1);
        expect_val(4, 32'd0, "R10 rearm count");
        expect_val(5, 32'd0, "R10 rearm done"); settle();

        tick(2);
        if (exp_q.size() != 0) begin
            errors++;
            $display("FAIL scoreboard leftover actual=%0d expected=0", exp_q.size());
        end
        if (!finished) begin
            finished = 1;
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        #100000;
        if (!finished) begin
            finished = 1;
            errors++; checks++;
            $display("FAIL watchdog actual=timeout expected=completion");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

endmodule